// File: doc/BRIEF.md
# Six-Channel PWM Generator with Lead-In Delay and Repeat Count

This peripheral produces six independent pulse-width-modulated outputs. Software programs each channel through two 32-bit words on a simple word-addressed register port: a control word carrying an enable flag, a lead-in delay and a repeat count, and a timing word carrying separate high-time and low-time counts. All counts are in input clock cycles.

Once enabled, a channel holds its output low for the lead-in delay. It then produces periods of `high` cycles high followed by `low` cycles low. The repeat count limits how many periods run; zero means they run without end. Timing words are held as a shadow copy that the running counters pick up only at a period boundary or at enable, so a new timing value never cuts a period short. Clearing the enable flag, by contrast, forces the output low on the very next cycle.

The register port takes a write strobe, a word address and write data, and returns read data combinationally for the address presented. Word addresses 0 to 5 select the control words of channels 0 to 5. Word addresses 8 to 13 select their timing words.

Top module: `leadin_pwm_top`

## Requirements
- R1: After reset every output is low and every register reads zero.
- R2: A write to word address n (n < 6) sets the control word of channel n, and a write to word address 8+n sets its timing word. Both read back exactly as written. Word addresses 6, 7, 14 and 15 read zero and ignore writes.
- R3: Control bit 31 is the channel enable. While it is clear the channel output is low.
- R4: Control bits 30:16 give a lead-in of L cycles. A write that sets the enable takes effect at clock edge k. The output is then low for the cycle after k and for L further cycles, and the first period starts on the cycle after those.
- R5: Timing bits 31:16 give the high count H and bits 15:0 give the low count L2. Each period is H cycles high followed by L2 cycles low, and periods follow each other without gaps.
- R6: A timing write while a channel runs does not change the period in progress. The new counts apply from the next period onward.
- R7: Control bits 15:0 give a repeat count N. With N = 0 the periods repeat forever. With N > 0 the output stays low after N periods, and the enable bit still reads back set.
- R8: A write that clears the enable drives the output low from the cycle that follows the write's clock edge, even in the middle of a high phase.
- R9: H = 0 makes the output low for the whole period. L2 = 0 with H > 0 makes it high continuously. H = L2 = 0 keeps it low.
- R10: Channels run independently: programming one channel does not change the waveform of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all counts are in its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 4 | Word address (bit 3 selects the timing bank) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the word at reg_addr_i |
| pwm_o | output | 6 | One PWM output per channel |

## Verification
The properties take the register port to be the only source of enable changes. A newly set enable therefore always finds its channel idle, and a channel that has finished its repeats leaves that state only when its enable is cleared. The bench drives the port only on falling clock edges with single-cycle write strobes. It programs channels through that port alone, and it never asserts the write strobe while reset is active, so every enable edge the properties see comes from an ordinary register write.

// File: rtl/leadin_pwm_pkg.sv
package leadin_pwm_pkg;
    localparam int REG_W  = 32;
    localparam int CNT_W  = 16;
    localparam int LEAD_W = 15;
    localparam int EN_BIT = 31;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_LEAD = 2'd1,
        CH_RUN  = 2'd2,
        CH_DONE = 2'd3
    } ch_state_e;

    typedef struct packed {
        ch_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] nper;
    } chan_t;
endpackage

// File: rtl/leadin_pwm_regs.sv
module leadin_pwm_regs
    import leadin_pwm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 4
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           we_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [REG_W-1:0]               wdata_i,
    output logic [REG_W-1:0]               rdata_o,
    output logic [NUM_CH-1:0][REG_W-1:0]   ctrl_o,
    output logic [NUM_CH-1:0][REG_W-1:0]   tim_o
);
    localparam int IDX_W = ADDR_W - 1;

    typedef struct packed {
        logic [NUM_CH-1:0][REG_W-1:0] ctrl;
        logic [NUM_CH-1:0][REG_W-1:0] tim;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic              bank_sel;
    logic [IDX_W-1:0]  idx;
    logic              idx_ok;

    assign bank_sel = addr_i[ADDR_W-1];
    assign idx      = addr_i[IDX_W-1:0];
    assign idx_ok   = (int'(idx) < NUM_CH);

    always_comb begin
        regs_d = regs_q;
        if (we_i && idx_ok) begin
            if (bank_sel) regs_d.tim[idx]  = wdata_i;
            else          regs_d.ctrl[idx] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    always_comb begin
        rdata_o = '0;
        if (idx_ok) rdata_o = bank_sel ? regs_q.tim[idx] : regs_q.ctrl[idx];
    end

    assign ctrl_o = regs_q.ctrl;
    assign tim_o  = regs_q.tim;
endmodule

// File: rtl/leadin_pwm_chan.sv
module leadin_pwm_chan
    import leadin_pwm_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [LEAD_W-1:0] lead_i,
    input  logic [CNT_W-1:0]  rep_i,
    input  logic [CNT_W-1:0]  hi_i,
    input  logic [CNT_W-1:0]  lo_i,
    output logic              pwm_o,
    output logic              run_o,
    output logic              done_o
);
    localparam logic [CNT_W:0]   WIDE_ONE = 1;
    localparam logic [CNT_W-1:0] CNT_ONE  = 1;

    chan_t          ch_d, ch_q;
    logic [CNT_W:0] cnt_inc, per_len, lead_ext, rep_ext, nper_inc;

    always_comb begin
        ch_d     = ch_q;
        cnt_inc  = {1'b0, ch_q.cnt} + WIDE_ONE;
        per_len  = {1'b0, ch_q.hi} + {1'b0, ch_q.lo};
        lead_ext = {{(CNT_W + 1 - LEAD_W){1'b0}}, lead_i};
        rep_ext  = {1'b0, rep_i};
        nper_inc = {1'b0, ch_q.nper} + WIDE_ONE;
        if (!en_i) begin
            ch_d.st  = CH_IDLE;
            ch_d.cnt = '0;
        end else begin
            unique case (ch_q.st)
                CH_IDLE: begin
                    ch_d.hi   = hi_i;
                    ch_d.lo   = lo_i;
                    ch_d.nper = '0;
                    ch_d.cnt  = '0;
                    ch_d.st   = (lead_i != '0) ? CH_LEAD : CH_RUN;
                end
                CH_LEAD: begin
                    if (cnt_inc >= lead_ext) begin
                        ch_d.st  = CH_RUN;
                        ch_d.cnt = '0;
                    end else begin
                        ch_d.cnt = ch_q.cnt + CNT_ONE;
                    end
                end
                CH_RUN: begin
                    if (cnt_inc >= per_len) begin
                        ch_d.cnt  = '0;
                        ch_d.hi   = hi_i;
                        ch_d.lo   = lo_i;
                        ch_d.nper = nper_inc[CNT_W-1:0];
                        if (rep_i != '0 && nper_inc >= rep_ext) ch_d.st = CH_DONE;
                    end else begin
                        ch_d.cnt = ch_q.cnt + CNT_ONE;
                    end
                end
                default: ch_d = ch_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ch_q <= '0;
        else         ch_q <= ch_d;
    end

    assign run_o  = (ch_q.st == CH_RUN);
    assign done_o = (ch_q.st == CH_DONE);
    assign pwm_o  = en_i && run_o && (ch_q.cnt < ch_q.hi);
endmodule

// File: rtl/leadin_pwm_top.sv
module leadin_pwm_top
    import leadin_pwm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic [NUM_CH-1:0] pwm_o
);
    logic [NUM_CH-1:0][REG_W-1:0] ctrl_w, tim_w;
    logic [NUM_CH-1:0]            chan_en, chan_run, chan_done;

    leadin_pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .ctrl_o  (ctrl_w),
        .tim_o   (tim_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign chan_en[g] = ctrl_w[g][EN_BIT];
        leadin_pwm_chan u_chan (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (chan_en[g]),
            .lead_i (ctrl_w[g][EN_BIT-1 -: LEAD_W]),
            .rep_i  (ctrl_w[g][CNT_W-1:0]),
            .hi_i   (tim_w[g][REG_W-1 -: CNT_W]),
            .lo_i   (tim_w[g][CNT_W-1:0]),
            .pwm_o  (pwm_o[g]),
            .run_o  (chan_run[g]),
            .done_o (chan_done[g])
        );
    end
endmodule

// File: rtl/leadin_pwm_checker.sv
module leadin_pwm_checker #(
    parameter int NUM_CH = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NUM_CH-1:0] en_i,
    input logic [NUM_CH-1:0] run_i,
    input logic [NUM_CH-1:0] done_i,
    input logic [NUM_CH-1:0] pwm_i
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
        AST_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni) !en_i[g] |-> !pwm_i[g]); // R3
        AST_QUIET_AFTER_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(en_i[g]) |-> !pwm_i[g]); // R4
        AST_HIGH_ONLY_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni) pwm_i[g] |-> run_i[g]); // R5
        AST_LOW_WHEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_i[g] |-> !pwm_i[g]); // R7
        AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni) (done_i[g] && en_i[g]) |=> (done_i[g] || !en_i[g])); // R7
        AST_DROP_IS_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(en_i[g]) |-> !pwm_i[g]); // R8
    end
endmodule

bind leadin_pwm_top leadin_pwm_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (chan_en),
    .run_i  (chan_run),
    .done_i (chan_done),
    .pwm_i  (pwm_o)
);

// File: tb/tb_leadin_pwm_top.sv
module tb_leadin_pwm_top;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  pwm;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    logic [31:0] mctrl [NCH];
    logic [31:0] mtim  [NCH];
    int          mst [NCH];
    int          mcnt [NCH];
    int          mhi [NCH];
    int          mlo [NCH];
    int          mnp [NCH];

    always #5 clk = ~clk;

    leadin_pwm_top dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pwm_o       (pwm)
    );

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit mout(input int c);
        return mctrl[c][31] && mst[c] == 2 && mcnt[c] < mhi[c];
    endfunction

    task automatic mstep(input int c);
        int en, lead, rep, hi, lo;
        en = int'(mctrl[c][31]);
        lead = int'(mctrl[c][30:16]);
        rep = int'(mctrl[c][15:0]);
        hi = int'(mtim[c][31:16]);
        lo = int'(mtim[c][15:0]);
        if (en == 0) begin
            mst[c] = 0; mcnt[c] = 0;
        end else if (mst[c] == 0) begin
            mhi[c] = hi; mlo[c] = lo; mnp[c] = 0; mcnt[c] = 0;
            mst[c] = (lead != 0) ? 1 : 2;
        end else if (mst[c] == 1) begin
            if (mcnt[c] + 1 >= lead) begin mst[c] = 2; mcnt[c] = 0; end
            else mcnt[c]++;
        end else if (mst[c] == 2) begin
            if (mcnt[c] + 1 >= mhi[c] + mlo[c]) begin
                mcnt[c] = 0; mhi[c] = hi; mlo[c] = lo; mnp[c]++;
                if (rep != 0 && mnp[c] >= rep) mst[c] = 3;
            end else mcnt[c]++;
        end
    endtask

    // reference model: advances on each rising edge from the pre-edge register values
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                mctrl[c] = '0; mtim[c] = '0; mst[c] = 0; mcnt[c] = 0;
                mhi[c] = 0; mlo[c] = 0; mnp[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) mstep(c);
            if (we) begin
                if (addr < 4'd8 && int'(addr) < NCH) mctrl[addr[2:0]] = wdata;
                else if (addr >= 4'd8 && int'(addr[2:0]) < NCH) mtim[addr[2:0]] = wdata;
            end
        end
    end

    // cycle-by-cycle comparison of every output against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++)
                chk(pwm[c] == mout(c), cur_req, $sformatf("pwm[%0d] vs model", c), pwm[c], mout(c));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk(v == 32'h0, "R1", $sformatf("reset read word %0d", a), v, 0);
        end
        chk(pwm == 6'h0, "R1", "reset outputs", pwm, 0);

        // R2: register map and readback
        cur_req = "R2";
        wr(4'd8, 32'h0003_0002);
        wr(4'd13, 32'h1234_5678);
        wr(4'd5, 32'h0055_0000);
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd14, 32'hFFFF_FFFF);
        rd(4'd8, v);  chk(v == 32'h0003_0002, "R2", "timing ch0", v, 32'h0003_0002);
        rd(4'd13, v); chk(v == 32'h1234_5678, "R2", "timing ch5", v, 32'h1234_5678);
        rd(4'd5, v);  chk(v == 32'h0055_0000, "R2", "control ch5", v, 32'h0055_0000);
        rd(4'd6, v);  chk(v == 32'h0, "R2", "unused word 6", v, 0);
        rd(4'd14, v); chk(v == 32'h0, "R2", "unused word 14", v, 0);
        wr(4'd5, 32'h0);
        wr(4'd13, 32'h0);

        // R4, R5: lead-in then free-running periods on channel 0
        cur_req = "R4/R5";
        wr(4'd0, 32'h8004_0000);
        @(negedge clk);
        chk(pwm[0] == 1'b0, "R4", "low right after enable", pwm[0], 0);
        repeat (30) @(negedge clk);

        // R6: timing change mid-period waits for the boundary
        cur_req = "R6";
        wr(4'd8, 32'h0001_0004);
        repeat (20) @(negedge clk);

        // R9, R10: degenerate counts on other channels while channel 0 runs
        cur_req = "R9/R10";
        wr(4'd9, 32'h0000_0003);
        wr(4'd10, 32'h0004_0000);
        wr(4'd11, 32'h0000_0000);
        wr(4'd1, 32'h8000_0000);
        wr(4'd2, 32'h8002_0000);
        wr(4'd3, 32'h8000_0000);
        repeat (12) @(negedge clk);
        chk(pwm[1] == 1'b0, "R9", "high count zero stays low", pwm[1], 0);
        chk(pwm[2] == 1'b1, "R9", "low count zero stays high", pwm[2], 1);
        chk(pwm[3] == 1'b0, "R9", "both zero stays low", pwm[3], 0);

        // R7: three periods then stop with enable still set
        cur_req = "R7";
        wr(4'd12, 32'h0002_0001);
        wr(4'd4, 32'h8000_0003);
        repeat (20) @(negedge clk);
        chk(pwm[4] == 1'b0, "R7", "output low after repeats", pwm[4], 0);
        rd(4'd4, v);
        chk(v == 32'h8000_0003, "R7", "enable still set", v, 32'h8000_0003);

        // R8: disable in the middle of a high phase
        cur_req = "R8";
        wr(4'd8, 32'h0008_0002);
        repeat (15) @(negedge clk);
        while (pwm[0] != 1'b1) @(negedge clk);
        @(negedge clk);
        chk(pwm[0] == 1'b1, "R8", "still high before disable", pwm[0], 1);
        we = 1'b1; addr = 4'd0; wdata = 32'h0;
        @(negedge clk);
        we = 1'b0;
        chk(pwm[0] == 1'b0, "R8", "low right after disable", pwm[0], 0);
        repeat (10) @(negedge clk);
        chk(pwm[0] == 1'b0, "R3", "disabled channel low", pwm[0], 0);

        finish_run();
    end
endmodule